// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a byte-addressed processor with a 16-bit address and main memory. Memory is seen as 8-byte blocks. The cache holds 256 sets, and each set has two lines. A processor address splits into three fields: a 5-bit tag in bits [15:11], an 8-bit set index in bits [10:3], and a byte offset in bits [2:0]. On each access the controller compares both lines of the indexed set at the same time. Each line keeps one recency bit, and the replacement choice comes from those bits.

Reads that hit complete in the same cycle as the request. Reads that miss fetch the whole block from memory and install it in a victim line. The requested byte is returned in the cycle the block arrives. Every write goes to memory. A write that hits also updates the cached byte, and a write that misses does not allocate a line.

A separate snoop input reports writes made by other bus masters. It carries the block address of each such write. A resident copy of that block is dropped.

Top module: `sa2_cache`

## Requirements
- R1: Address fields are tag = addr[15:11], set = addr[10:3] and offset = addr[2:0]. A read miss presents the block number addr[15:3] on `mem_rd_addr`. For example, address 18444 is tag 9, set 1, offset 4, and is fetched as block 2305.
- R2: Both lines of the indexed set are compared. A read that hits raises `cpu_ready` with the addressed byte in the same cycle the request is presented, and starts no memory read.
- R3: Every reference sets the referenced line's recency bit to 1 and clears the other line's bit in that set. A reference is a read hit, a fill, or a write hit.
- R4: The refill victim is an invalid line if the set has one, with way 0 taken when both are invalid. Otherwise the victim is the line whose recency bit is 0.
- R5: A read miss holds `mem_rd_req` and a stable block address until `mem_rd_ack`. In the acknowledge cycle the block on `mem_rd_data` fills the victim line, and `cpu_ready` rises with byte k of the block. Byte k is `mem_rd_data[8k+7:8k]`, with k the offset.
- R6: Every write holds `mem_wr_req`, its byte address and its data until `mem_wr_ack`, and `cpu_ready` rises in that cycle. On a write hit the cached byte is updated in the same cycle, so a later read hits with the new value.
- R7: A write miss allocates no line and fetches no block. A following read of that address misses.
- R8: When `snp_valid` is high and `snp_block` names a resident block, that line is invalid from the next edge. Recency bits are left unchanged.
- R9: If a snoop and an idle-state processor request name the same set in the same cycle, the request is not served in that cycle (`cpu_ready` stays low) and the invalidate is applied first.
- R10: After reset every line is invalid, every recency bit is 0, and `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` on reads |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | 13 | Block number to read |
| mem_rd_ack | input | 1 | Block data valid this cycle |
| mem_rd_data | input | 64 | Block data, byte k at bits [8k+7:8k] |
| mem_wr_req | output | 1 | Byte write request |
| mem_wr_addr | output | 16 | Byte address to write |
| mem_wr_data | output | 8 | Byte to write |
| mem_wr_ack | input | 1 | Memory accepts the write this cycle |
| snp_valid | input | 1 | Another master writes memory this cycle |
| snp_block | input | 13 | Block number of that write |

## Verification
The assertions assume the processor keeps `cpu_req` and its address, direction and data steady until `cpu_ready`. They also assume memory raises each acknowledge only while the matching request is high. Snoops are taken to arrive only while the controller is idle, never during an outstanding fill or write. The bench drives each request from one negative edge until completion, and gives memory acknowledges a latency of one to three cycles. It raises a snoop only in the first cycle of a request or on its own between requests, so a snoop never overlaps a transfer already under way.

// File: rtl/sa2_pkg.sv
package sa2_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } sa2_state_e;
endpackage

// File: rtl/sa2_way.sv
module sa2_way #(
  parameter int TAG_W  = 5,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 3,
  parameter int BYTE_W = 8,
  localparam int LINE_W = BYTE_W << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic [LINE_W-1:0] lk_line,
  input  logic              snp_valid,
  input  logic [SET_W-1:0]  snp_set,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              upd_en,
  input  logic [OFF_W-1:0]  upd_off,
  input  logic [BYTE_W-1:0] upd_byte
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  // named events for the checks below
  logic snp_hit;
  logic snp_kills_fill;

  assign snp_hit        = snp_valid && valid_q[snp_set] && (tag_q[snp_set] == snp_tag);
  assign snp_kills_fill = fill_en && snp_valid && (snp_set == lk_set) && (snp_tag == lk_tag);

  assign lk_valid = valid_q[lk_set];
  assign lk_line  = line_q[lk_set];
  assign lk_hit   = lk_valid && (tag_q[lk_set] == lk_tag);

  // invalidate first, then a fill of a different block may set the slot again
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (snp_hit) valid_q[snp_set] <= 1'b0;
      if (fill_en && !snp_kills_fill) valid_q[lk_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[lk_set]  <= lk_tag;
      line_q[lk_set] <= fill_line;
    end else if (upd_en) begin
      line_q[lk_set][upd_off*BYTE_W +: BYTE_W] <= upd_byte;
    end
  end

  AST_SNOOP_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n) (snp_hit && !(fill_en && snp_set == lk_set)) |=> !valid_q[$past(snp_set)]); // R8
endmodule

// File: rtl/sa2_repl.sv
module sa2_repl #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic             valid0,
  input  logic             valid1,
  input  logic             ref_en,
  input  logic             ref_way,
  output logic             victim
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] use0_q;
  logic [SETS-1:0] use1_q;

  // empty line first (way 0 on a tie), then the line not used last
  function automatic logic pick_victim(input logic v0, input logic v1,
                                       input logic u0, input logic u1);
    if (!v0) return 1'b0;
    if (!v1) return 1'b1;
    if (!u0) return 1'b0;
    return !u1 ? 1'b1 : 1'b0;
  endfunction

  assign victim = pick_victim(valid0, valid1, use0_q[lk_set], use1_q[lk_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use0_q <= '0;
      use1_q <= '0;
    end else if (ref_en) begin
      use0_q[lk_set] <= !ref_way;
      use1_q[lk_set] <= ref_way;
    end
  end

  AST_USE_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n) ref_en |=> (use0_q[$past(lk_set)] == !$past(ref_way)) && (use1_q[$past(lk_set)] == $past(ref_way))); // R3
  AST_VICTIM_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (valid0 != valid1) |-> (victim == valid0)); // R4
endmodule

// File: rtl/sa2_ctrl.sv
module sa2_ctrl
  import sa2_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 3,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = TAG_W + SET_W + OFF_W,
  localparam int BLK_W  = TAG_W + SET_W,
  localparam int LINE_W = BYTE_W << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [BLK_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [BYTE_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  input  logic              snp_valid,
  input  logic [BLK_W-1:0]  snp_block,
  input  logic [WAYS-1:0]   hit_vec,
  input  logic [LINE_W-1:0] hit_line,
  input  logic              victim,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              fill_en,
  output logic              upd_en,
  output logic              ref_en,
  output logic              ref_way
);
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(input logic [LINE_W-1:0] line,
                                                input logic [OFF_W-1:0] off);
    return line[off*BYTE_W +: BYTE_W];
  endfunction

  sa2_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [BYTE_W-1:0] req_wdata_q;

  // named events
  logic idle;
  logic snp_block_cpu;
  logic accept;
  logic any_hit;
  logic rd_hit;
  logic rd_miss_go;
  logic wr_go;
  logic fill_done;
  logic wr_done;

  assign idle          = (state_q == ST_IDLE);
  assign snp_block_cpu = snp_valid && (snp_block[SET_W-1:0] == set_of(cpu_addr));
  assign accept        = idle && cpu_req && !snp_block_cpu;
  assign any_hit       = |hit_vec;
  assign rd_hit        = accept && !cpu_we && any_hit;
  assign rd_miss_go    = accept && !cpu_we && !any_hit;
  assign wr_go         = accept && cpu_we;
  assign fill_done     = (state_q == ST_FILL) && mem_rd_ack;
  assign wr_done       = (state_q == ST_WRITE) && mem_wr_ack;

  assign lk_addr = idle ? cpu_addr : req_addr_q;
  assign fill_en = fill_done;
  assign upd_en  = wr_done && any_hit;
  assign ref_en  = rd_hit || fill_done || upd_en;
  assign ref_way = fill_done ? victim : hit_vec[1];

  assign cpu_ready = rd_hit || fill_done || wr_done;

  always_comb begin
    cpu_rdata = '0;
    if (rd_hit)         cpu_rdata = byte_of(hit_line, off_of(cpu_addr));
    else if (fill_done) cpu_rdata = byte_of(mem_rd_data, off_of(req_addr_q));
  end

  assign mem_rd_req  = (state_q == ST_FILL);
  assign mem_rd_addr = blk_of(req_addr_q);
  assign mem_wr_req  = (state_q == ST_WRITE);
  assign mem_wr_addr = req_addr_q;
  assign mem_wr_data = req_wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rd_miss_go) begin
            state_q    <= ST_FILL;
            req_addr_q <= cpu_addr;
          end else if (wr_go) begin
            state_q     <= ST_WRITE;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
          end
        end
        ST_FILL:  if (mem_rd_ack) state_q <= ST_IDLE;
        ST_WRITE: if (mem_wr_ack) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R2
  AST_MISS_HOLDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R5
  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R6
  AST_WRITE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_req |-> !mem_rd_req && !fill_en); // R7
  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n) (idle && cpu_req && snp_valid && snp_block[SET_W-1:0] == cpu_addr[OFF_W +: SET_W]) |-> !cpu_ready); // R9
endmodule

// File: rtl/sa2_cache.sv
module sa2_cache
  import sa2_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 3,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = TAG_W + SET_W + OFF_W,
  localparam int BLK_W  = TAG_W + SET_W,
  localparam int LINE_W = BYTE_W << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [BLK_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [BYTE_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  input  logic              snp_valid,
  input  logic [BLK_W-1:0]  snp_block
);
  logic [ADDR_W-1:0] lk_addr;
  logic              fill_en;
  logic              upd_en;
  logic              ref_en;
  logic              ref_way;
  logic              victim;
  logic [WAYS-1:0]   hit_vec;
  logic [WAYS-1:0]   valid_vec;
  logic [LINE_W-1:0] way_line [WAYS];
  logic [LINE_W-1:0] hit_line;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sa2_way #(
      .TAG_W (TAG_W),
      .SET_W (SET_W),
      .OFF_W (OFF_W),
      .BYTE_W(BYTE_W)
    ) i_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_set   (lk_addr[OFF_W +: SET_W]),
      .lk_tag   (lk_addr[ADDR_W-1 -: TAG_W]),
      .lk_hit   (hit_vec[w]),
      .lk_valid (valid_vec[w]),
      .lk_line  (way_line[w]),
      .snp_valid(snp_valid),
      .snp_set  (snp_block[SET_W-1:0]),
      .snp_tag  (snp_block[BLK_W-1 -: TAG_W]),
      .fill_en  (fill_en && (victim == 1'(w))),
      .fill_line(mem_rd_data),
      .upd_en   (upd_en && hit_vec[w]),
      .upd_off  (lk_addr[OFF_W-1:0]),
      .upd_byte (mem_wr_data)
    );
  end

  always_comb begin
    hit_line = way_line[0];
    for (int w = 1; w < WAYS; w++) begin
      if (hit_vec[w]) hit_line = way_line[w];
    end
  end

  sa2_repl #(
    .SET_W(SET_W)
  ) i_repl (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_set (lk_addr[OFF_W +: SET_W]),
    .valid0 (valid_vec[0]),
    .valid1 (valid_vec[1]),
    .ref_en (ref_en),
    .ref_way(ref_way),
    .victim (victim)
  );

  sa2_ctrl #(
    .TAG_W (TAG_W),
    .SET_W (SET_W),
    .OFF_W (OFF_W),
    .BYTE_W(BYTE_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .mem_rd_req (mem_rd_req),
    .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack (mem_rd_ack),
    .mem_rd_data(mem_rd_data),
    .mem_wr_req (mem_wr_req),
    .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .mem_wr_ack (mem_wr_ack),
    .snp_valid  (snp_valid),
    .snp_block  (snp_block),
    .hit_vec    (hit_vec),
    .hit_line   (hit_line),
    .victim     (victim),
    .lk_addr    (lk_addr),
    .fill_en    (fill_en),
    .upd_en     (upd_en),
    .ref_en     (ref_en),
    .ref_way    (ref_way)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> !mem_rd_req && !mem_wr_req); // R10
endmodule

// File: tb/test_sa2_cache.sv
module test_sa2_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic        mem_rd_req;
  logic [12:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        mem_wr_req;
  logic [15:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        mem_wr_ack = 1'b0;
  logic        snp_valid = 1'b0;
  logic [12:0] snp_block = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa2_cache i_sa2_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .snp_valid(snp_valid), .snp_block(snp_block)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- main memory model ----------------
  logic [7:0] bmem [int];

  function automatic logic [7:0] mem_byte(input int a);
    if (bmem.exists(a)) return bmem[a];
    return 8'((a * 29) ^ (a >> 5));
  endfunction

  int rd_cnt = 0, wr_cnt = 0, rd_lat = 0, wr_lat = 0;
  int last_rd_blk = -1, last_wr_addr = -1;
  logic [7:0] last_wr_data = '0;

  always @(posedge clk) begin
    #1;
    if (mem_rd_ack) mem_rd_ack = 1'b0;
    else if (mem_rd_req) begin
      rd_lat++;
      if (rd_lat >= 1 + (rd_cnt % 3)) begin
        for (int k = 0; k < 8; k++) mem_rd_data[k*8 +: 8] = mem_byte(int'(mem_rd_addr) * 8 + k);
        last_rd_blk = int'(mem_rd_addr);
        rd_cnt++;
        rd_lat = 0;
        mem_rd_ack = 1'b1;
      end
    end
    if (mem_wr_ack) mem_wr_ack = 1'b0;
    else if (mem_wr_req) begin
      wr_lat++;
      if (wr_lat >= 1 + (wr_cnt % 2)) begin
        bmem[int'(mem_wr_addr)] = mem_wr_data;
        last_wr_addr = int'(mem_wr_addr);
        last_wr_data = mem_wr_data;
        wr_cnt++;
        wr_lat = 0;
        mem_wr_ack = 1'b1;
      end
    end
  end

  // ---------------- cache reference model ----------------
  bit       m_valid [256][2];
  bit [4:0] m_tag   [256][2];
  bit       m_use   [256][2];

  function automatic int f_tag(input int a); return a / 2048; endfunction
  function automatic int f_set(input int a); return (a / 8) % 256; endfunction

  function automatic int m_find(input int a);
    for (int w = 0; w < 2; w++)
      if (m_valid[f_set(a)][w] && int'(m_tag[f_set(a)][w]) == f_tag(a)) return w;
    return -1;
  endfunction

  function automatic int m_victim(input int s);
    if (!m_valid[s][0]) return 0;
    if (!m_valid[s][1]) return 1;
    if (!m_use[s][0]) return 0;
    return 1;
  endfunction

  function automatic void m_touch(input int s, input int w);
    m_use[s][w] = 1;
    m_use[s][1-w] = 0;
  endfunction

  function automatic void m_snoop(input int blk);
    for (int w = 0; w < 2; w++)
      if (m_valid[blk % 256][w] && int'(m_tag[blk % 256][w]) == blk / 256) m_valid[blk % 256][w] = 0;
  endfunction

  // ---------------- stimulus tasks ----------------
  task automatic access(input int a, input bit we, input logic [7:0] wd,
                        input bit sn, input int sa, input string req);
    int way, rd0, wr0, cyc;
    bit first_rdy, conflict;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = 16'(a); cpu_wdata = wd;
    conflict = sn && (f_set(sa) == f_set(a));
    if (sn) begin
      snp_valid = 1; snp_block = 13'(sa / 8);
      bmem[sa] = 8'($urandom);
      m_snoop(sa / 8);
    end
    way = m_find(a);
    rd0 = rd_cnt; wr0 = wr_cnt; cyc = 0;
    #2;
    first_rdy = cpu_ready;
    while (!cpu_ready && cyc < 60) begin
      @(negedge clk);
      snp_valid = 0;
      #2;
      cyc++;
    end
    chk(cyc < 60, req, "request completes", cyc, 0);
    if (conflict) chk(!first_rdy, "R9", "snoop on same set delays request", int'(first_rdy), 0);
    if (!we) begin
      chk(cpu_rdata == mem_byte(a), (way >= 0) ? "R2" : "R5", "read byte", int'(cpu_rdata), int'(mem_byte(a)));
      chk((rd_cnt != rd0) == (way < 0), req, "miss predicted by model", int'(rd_cnt != rd0), int'(way < 0));
      if (way >= 0 && !conflict) chk(first_rdy, "R2", "hit ready in request cycle", int'(first_rdy), 1);
      if (way < 0) chk(last_rd_blk == a / 8, "R1", "fetched block number", last_rd_blk, a / 8);
      if (way >= 0) m_touch(f_set(a), way);
      else begin
        int v;
        v = m_victim(f_set(a));
        m_valid[f_set(a)][v] = 1;
        m_tag[f_set(a)][v] = 5'(f_tag(a));
        m_touch(f_set(a), v);
      end
    end else begin
      chk(wr_cnt == wr0 + 1, "R6", "one memory write", wr_cnt - wr0, 1);
      chk(last_wr_addr == a && last_wr_data == wd, "R6", "written address", last_wr_addr, a);
      chk(rd_cnt == rd0, "R7", "write fetches no block", rd_cnt - rd0, 0);
      if (way >= 0) m_touch(f_set(a), way);
    end
    @(negedge clk);
    cpu_req = 0; snp_valid = 0;
  endtask

  task automatic snoop_only(input int sa);
    @(negedge clk);
    snp_valid = 1; snp_block = 13'(sa / 8);
    bmem[sa] = 8'($urandom);
    m_snoop(sa / 8);
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run stalled, actual 0 expected 1");
    wrap_up();
  end

  localparam int A_ADR = 18444;                      // tag 9, set 1, offset 4
  localparam int B_ADR = (3 << 11) | (1 << 3) | 2;   // tag 3, set 1
  localparam int C_ADR = (5 << 11) | (1 << 3) | 7;   // tag 5, set 1
  localparam int D_ADR = (20 << 11) | (7 << 3) | 1;  // tag 20, set 7

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    chk(!cpu_ready, "R10", "ready low after reset", int'(cpu_ready), 0);
    chk(!mem_rd_req, "R10", "no block read after reset", int'(mem_rd_req), 0);
    chk(!mem_wr_req, "R10", "no write after reset", int'(mem_wr_req), 0);

    access(A_ADR, 0, 8'h00, 0, 0, "R10");   // empty cache misses
    chk(last_rd_blk == 2305, "R1", "block for 18444", last_rd_blk, 2305);
    access(A_ADR, 0, 8'h00, 0, 0, "R2");
    access(B_ADR, 0, 8'h00, 0, 0, "R4");    // fills empty way 1
    access(A_ADR, 0, 8'h00, 0, 0, "R3");
    access(C_ADR, 0, 8'h00, 0, 0, "R4");    // evicts B
    access(A_ADR, 0, 8'h00, 0, 0, "R3");
    access(B_ADR, 0, 8'h00, 0, 0, "R4");    // evicts C
    access(C_ADR, 0, 8'h00, 0, 0, "R4");    // evicts A

    access(B_ADR, 1, 8'h3C, 0, 0, "R6");    // write hit
    access(B_ADR, 0, 8'h00, 0, 0, "R6");    // read back hits with new byte
    access(D_ADR, 1, 8'hA5, 0, 0, "R7");    // write miss
    access(D_ADR, 0, 8'h00, 0, 0, "R7");    // still a miss

    snoop_only(B_ADR);
    access(B_ADR, 0, 8'h00, 0, 0, "R8");    // dropped line misses
    snoop_only((7 << 11) | (40 << 3));      // block not resident
    access(C_ADR, 0, 8'h00, 0, 0, "R8");    // untouched line still hits

    access(C_ADR, 0, 8'h00, 1, C_ADR, "R9");               // same block
    access(B_ADR, 0, 8'h00, 1, A_ADR, "R9");               // same set, other tag
    access(B_ADR, 0, 8'h00, 1, (2 << 11) | (50 << 3), "R2"); // other set, no delay

    for (int i = 0; i < 1500; i++) begin
      int a, sa;
      bit we, sn;
      a  = int'($urandom % 4) * 2048 + int'($urandom % 4) * 8 + int'($urandom % 8);
      we = ($urandom % 10) < 3;
      sn = ($urandom % 100) < 15;
      sa = int'($urandom % 4) * 2048 + int'($urandom % 4) * 8 + int'($urandom % 8);
      access(a, we, 8'($urandom), sn, sa, "R4");
    end

    wrap_up();
  end
endmodule